// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Controller

This block is a bus master on the host side. It writes one byte into a parallel, byte-wide nonvolatile memory and then waits until the memory's internal programming cycle has finished. On the user side it takes a request with an 11-bit address and an 8-bit data value and acknowledges it in the same cycle. When the write is over it raises a one-cycle completion pulse, or a one-cycle timeout pulse if the memory never reports that it is finished. On the memory side it drives the active-low chip select, output enable and write strobe, the address bus and a data bus that it can release, and it reads the memory's ready line.

All strobe timing is set by nanosecond parameters. Each one is rounded up to a whole number of clock cycles. The states are:

- `ST_IDLE`: waiting for a request. A request moves to `ST_SETUP`.
- `ST_SETUP`: address settling time. When its phase ends it moves to `ST_STROBE`.
- `ST_STROBE`: the write strobe is low. When its phase ends it moves to `ST_HOLD`.
- `ST_HOLD`: data hold time. When its phase ends it moves to `ST_WAIT_BUSY`.
- `ST_WAIT_BUSY`: a blind wait that covers the memory's busy-assertion delay. When its phase ends it moves to `ST_POLL`.
- `ST_POLL`: the controller watches for completion. In the bit-7 method it reads the memory and, if the value does not yet match, moves to `ST_POLL_GAP`. When completion is seen it moves to `ST_DONE`.
- `ST_POLL_GAP`: output enable is high for a recovery time. When its phase ends it moves back to `ST_POLL`.
- `ST_DONE` and `ST_TIMEOUT`: each lasts one cycle and then returns to `ST_IDLE`.

Any of the three wait states moves to `ST_TIMEOUT` when the wait limit runs out.

A detection-method input is latched with each request and selects one of two ways to detect that the write is finished:
- bit-7 comparison: the controller reads back the written location;
- ready pin: the controller waits for the ready line to go high.

Top module: `eew_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and mem_we_n are all 1, mem_dq_oe is 0, and ack, done and timeout_err are all 0.
- R2: In ST_IDLE, req=1 gives ack=1 in the same cycle, and wr_addr, wr_data and det_mode are captured. In every other state ack stays 0 and changes on the request inputs have no effect on the address or data that is written.
- R3: Before mem_we_n falls, there is a setup phase of exactly max(ceil(10 ns), ceil(15 ns), ceil(55 ns)) clock cycles. During this phase mem_ce_n=0, mem_oe_n=1, mem_we_n=1 and the captured address is on mem_addr.
- R4: mem_we_n stays 0 for exactly max(ceil(150 ns), ceil(50 ns), ceil(100 ns)) cycles. Throughout that time mem_dq_oe=1, mem_dq_out holds the captured data, mem_addr holds the captured address, mem_oe_n=1 and mem_ce_n=0. The memory therefore stores that byte at that address.
- R5: After mem_we_n rises, mem_dq_oe stays 1 with stable data and mem_oe_n stays 1 for exactly max(ceil(10 ns), ceil(15 ns)) cycles. mem_dq_oe then falls.
- R6: Completion is not sampled until ceil(80 ns) cycles after the hold phase ends. In bit-7 mode, the first read (mem_oe_n=0) starts exactly hold + ceil(80 ns) cycles after mem_we_n rises.
- R7: Bit-7 mode (det_mode=0): each read holds mem_ce_n=0 and mem_oe_n=0 with mem_dq_oe=0 for ceil(200 ns) cycles. The controller then samples mem_dq_in[7]. If it equals bit 7 of the written data, done follows. Otherwise mem_oe_n is high for max(ceil(15 ns), ceil(55 ns)) cycles before the next read.
- R8: Ready-pin mode (det_mode=1): mem_oe_n stays 1 throughout. done follows within SYNC_STAGES+2 cycles of mem_rdy going high, after that line passes through a SYNC_STAGES-flop synchronizer.
- R9: If completion is not seen within ceil(TIMEOUT_NS) cycles counted from the start of ST_WAIT_BUSY, timeout_err pulses instead of done. That pulse comes exactly hold + ceil(TIMEOUT_NS) cycles after mem_we_n rises.
- R10: done and timeout_err are never high together. Each lasts one cycle, in the next cycle mem_ce_n=1, and a new request is accepted afterwards.
- R11: mem_oe_n and mem_we_n are never 0 together, and mem_we_n=0 only while mem_ce_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Write request |
| ack | output | 1 | Request accepted (same cycle, ST_IDLE only) |
| wr_addr | input | AW (11) | Byte address to write |
| wr_data | input | DW (8) | Byte value to write |
| det_mode | input | 1 | 0 = bit-7 comparison, 1 = ready pin |
| done | output | 1 | One-cycle pulse: write completed |
| timeout_err | output | 1 | One-cycle pulse: completion not seen in time |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | AW (11) | Memory address bus |
| mem_dq_out | output | DW (8) | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW (8) | Data read from the memory |
| mem_rdy | input | 1 | Memory ready line, high when idle |

## Verification
A wrong state or a miscounted phase shows up directly as a changed run length on mem_we_n, mem_ce_n or mem_dq_oe. The bench counts these run lengths exactly in the same transaction, so a one-cycle error in any phase is caught before the status pulse. A wrong completion decision shows up as done arriving while the memory model is still busy, or as a wrong first-read cycle in bit-7 mode. A wrong wait limit shows up as timeout_err arriving at a cycle other than the exact expected one, which is checked against a memory that stays busy. A request-capture fault shows up in the stored byte, which the bench reads back from its own memory model immediately after done.

// File: rtl/eew_pkg.sv
package eew_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT_BUSY,
        ST_POLL,
        ST_POLL_GAP,
        ST_DONE,
        ST_TIMEOUT
    } eew_state_e;

    typedef enum logic {
        DET_BIT7 = 1'b0,
        DET_PIN  = 1'b1
    } eew_det_e;

    // Round a nanosecond interval up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eew_phase_timer.sv
// Down counter for one timed phase: load with length-1 on state entry,
// expire reads high on the last cycle of the phase.
module eew_phase_timer #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/eew_wait_limit.sv
// Counts cycles spent waiting for completion; flags the last allowed one.
module eew_wait_limit #(
    parameter int unsigned LIMIT = 1000,
    localparam int unsigned LW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam logic [LW-1:0] LAST = LW'(LIMIT - 1);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/eew_done_detect.sv
// Completion decision for either detection method.
module eew_done_detect
    import eew_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  eew_det_e mode,
    input  logic     rdy_raw,
    input  logic     rd_bit7,
    input  logic     want_bit7,
    input  logic     sample_now,
    input  logic     watch_pin,
    output logic     complete
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rdy_s;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= rdy_raw;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_raw};
            end
        end
    endgenerate

    assign rdy_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        unique case (mode)
            DET_PIN:  complete = watch_pin && rdy_s;
            DET_BIT7: complete = sample_now && (rd_bit7 == want_bit7);
            default:  complete = 1'b0;
        endcase
    end

endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl
    import eew_pkg::*;
#(
    parameter int unsigned AW          = 11,
    parameter int unsigned DW          = 8,
    parameter int unsigned CLK_NS      = 5,
    parameter int unsigned T_AS_NS     = 10,
    parameter int unsigned T_AH_NS     = 100,
    parameter int unsigned T_WP_NS     = 150,
    parameter int unsigned T_DS_NS     = 50,
    parameter int unsigned T_DH_NS     = 10,
    parameter int unsigned T_OES_NS    = 15,
    parameter int unsigned T_OEH_NS    = 15,
    parameter int unsigned T_DB_NS     = 80,
    parameter int unsigned T_ACC_NS    = 200,
    parameter int unsigned T_DF_NS     = 55,
    parameter int unsigned TIMEOUT_NS  = 10_500_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    output logic          ack,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          det_mode,
    output logic          done,
    output logic          timeout_err,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in,
    input  logic          mem_rdy
);

    // Phase lengths in cycles
    localparam int unsigned C_SETUP  = max2(max2(ns_to_cyc(T_AS_NS, CLK_NS),
                                                 ns_to_cyc(T_OES_NS, CLK_NS)),
                                            ns_to_cyc(T_DF_NS, CLK_NS));
    localparam int unsigned C_STROBE = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                                 ns_to_cyc(T_DS_NS, CLK_NS)),
                                            ns_to_cyc(T_AH_NS, CLK_NS));
    localparam int unsigned C_HOLD   = max2(ns_to_cyc(T_DH_NS, CLK_NS),
                                            ns_to_cyc(T_OEH_NS, CLK_NS));
    localparam int unsigned C_WAITB  = ns_to_cyc(T_DB_NS, CLK_NS);
    localparam int unsigned C_ACC    = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int unsigned C_GAP    = max2(ns_to_cyc(T_OEH_NS, CLK_NS),
                                            ns_to_cyc(T_DF_NS, CLK_NS));
    localparam int unsigned C_LIMIT  = ns_to_cyc(TIMEOUT_NS, CLK_NS);
    localparam int unsigned PH_MAX   = max2(max2(max2(C_SETUP, C_STROBE), max2(C_HOLD, C_WAITB)),
                                            max2(C_ACC, C_GAP));
    localparam int unsigned PH_W     = $clog2(PH_MAX + 1);

    eew_state_e     state_q, state_d;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    eew_det_e       mode_q;

    logic           ph_load;
    logic [PH_W-1:0] ph_val;
    logic           ph_exp;
    logic           wait_run;
    logic           to_exp;
    logic           complete;
    logic           in_poll;
    logic           poll_sample;
    logic           dq_low_unused;

    assign dq_low_unused = ^mem_dq_in[DW-2:0];

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            mode_q <= DET_BIT7;
        end else if (state_q == ST_IDLE && req) begin
            addr_q <= wr_addr;
            data_q <= wr_data;
            mode_q <= eew_det_e'(det_mode);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req)    state_d = ST_SETUP;
            ST_SETUP:     if (ph_exp) state_d = ST_STROBE;
            ST_STROBE:    if (ph_exp) state_d = ST_HOLD;
            ST_HOLD:      if (ph_exp) state_d = ST_WAIT_BUSY;
            ST_WAIT_BUSY: begin
                if (to_exp)      state_d = ST_TIMEOUT;
                else if (ph_exp) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (complete)    state_d = ST_DONE;
                else if (to_exp) state_d = ST_TIMEOUT;
                else if (mode_q == DET_BIT7 && ph_exp) state_d = ST_POLL_GAP;
            end
            ST_POLL_GAP: begin
                if (to_exp)      state_d = ST_TIMEOUT;
                else if (ph_exp) state_d = ST_POLL;
            end
            ST_DONE:      state_d = ST_IDLE;
            ST_TIMEOUT:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered
    always_comb begin
        unique case (state_d)
            ST_SETUP:     ph_val = PH_W'(C_SETUP - 1);
            ST_STROBE:    ph_val = PH_W'(C_STROBE - 1);
            ST_HOLD:      ph_val = PH_W'(C_HOLD - 1);
            ST_WAIT_BUSY: ph_val = PH_W'(C_WAITB - 1);
            ST_POLL:      ph_val = PH_W'(C_ACC - 1);
            ST_POLL_GAP:  ph_val = PH_W'(C_GAP - 1);
            default:      ph_val = '0;
        endcase
    end

    assign ph_load     = (state_d != state_q);
    assign wait_run    = (state_q == ST_WAIT_BUSY) || (state_q == ST_POLL) ||
                         (state_q == ST_POLL_GAP);
    assign in_poll     = (state_q == ST_POLL);
    assign poll_sample = in_poll && ph_exp;

    eew_phase_timer #(
        .CW       (PH_W)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expire   (ph_exp)
    );

    eew_wait_limit #(
        .LIMIT    (C_LIMIT)
    ) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (wait_run),
        .expired  (to_exp)
    );

    eew_done_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_q),
        .rdy_raw     (mem_rdy),
        .rd_bit7     (mem_dq_in[DW-1]),
        .want_bit7   (data_q[DW-1]),
        .sample_now  (poll_sample),
        .watch_pin   (in_poll),
        .complete    (complete)
    );

    // Outputs decoded from the state register
    always_comb begin
        mem_ce_n    = 1'b1;
        mem_oe_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_dq_oe   = 1'b0;
        ack         = 1'b0;
        done        = 1'b0;
        timeout_err = 1'b0;
        unique case (state_q)
            ST_IDLE:      ack = req;
            ST_SETUP:     mem_ce_n = 1'b0;
            ST_STROBE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WAIT_BUSY: mem_ce_n = 1'b0;
            ST_POLL: begin
                mem_ce_n = 1'b0;
                mem_oe_n = (mode_q == DET_PIN);
            end
            ST_POLL_GAP:  mem_ce_n = 1'b0;
            ST_DONE:      done = 1'b1;
            ST_TIMEOUT:   timeout_err = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = data_q;

endmodule

// File: rtl/eew_ctrl_chk.sv
module eew_ctrl_chk #(
    parameter int unsigned AW = 11,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          done,
    input logic          timeout_err,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R11

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n); // R11

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R4

    AST_DATA_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R4

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R5

    AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && mem_oe_n)); // R5

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R7

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout_err)); // R10

    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || timeout_err) |=> (!done && !timeout_err && mem_ce_n)); // R10

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R2

endmodule

bind eew_ctrl eew_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .done        (done),
    .timeout_err (timeout_err),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/eew_ctrl_tb.sv
`timescale 1ns/1ps
module eew_ctrl_tb;

    localparam int TO_NS = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ack;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        det_mode = 1'b0;
    logic        done, timeout_err;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [10:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic        mem_rdy;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    eew_ctrl #(.TIMEOUT_NS(TO_NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
        .wr_addr(wr_addr), .wr_data(wr_data), .det_mode(det_mode),
        .done(done), .timeout_err(timeout_err),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_rdy(mem_rdy)
    );

    // Expected cycle counts from the requirements (5 ns clock)
    function automatic int cyc(input int ns);
        int c;
        c = (ns + 4) / 5;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    int E_SETUP, E_STROBE, E_HOLD, E_DB, E_ACC, E_GAP, E_TO;

    // Memory model
    logic [7:0] model_mem [0:2047];
    int         busy_cnt = 0;
    int         busy_len = 1;
    bit         stuck = 0;
    logic       we_prev = 1'b1;
    logic       last7 = 1'b0;

    always_ff @(posedge clk) begin
        we_prev <= mem_we_n;
        if (!we_prev && mem_we_n && !mem_ce_n) begin
            model_mem[mem_addr] <= mem_dq_out;
            last7               <= mem_dq_out[7];
            busy_cnt            <= busy_len;
        end else if (busy_cnt != 0 && !stuck) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    assign mem_rdy   = (busy_cnt == 0);
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
                       ((busy_cnt != 0) ? {~last7, 7'h2A} : model_mem[mem_addr]) : 8'h00;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [10:0] a, input logic [7:0] d, input logic m,
                           input int blen, input bit stk, input bit pester);
        int  n, k, bend, first_oe, done_k, ref_k;
        bit  ok, fin, got_done, got_err, busy_at_done;
        busy_len = blen;
        stuck    = stk;
        @(negedge clk);
        req = 1'b1; wr_addr = a; wr_data = d; det_mode = m;
        #1;
        chk(ack == 1'b1, "R2 ack in idle", ack, 1);
        @(negedge clk);
        if (pester) begin
            wr_addr = ~a; wr_data = ~d;
        end else begin
            req = 1'b0;
        end
        // setup phase
        n = 0; ok = 1;
        while (mem_we_n && n < 1000) begin
            if (mem_ce_n || !mem_oe_n || mem_addr != a || ack) ok = 0;
            n++;
            @(negedge clk);
        end
        chk(n == E_SETUP, "R3 setup length", n, E_SETUP);
        chk(ok, "R3 setup levels / R2 no ack", ok, 1);
        // strobe phase
        n = 0; ok = 1;
        while (!mem_we_n && n < 1000) begin
            if (mem_ce_n || !mem_oe_n || !mem_dq_oe || mem_addr != a ||
                mem_dq_out != d || ack) ok = 0;
            n++;
            @(negedge clk);
        end
        chk(n == E_STROBE, "R4 strobe length", n, E_STROBE);
        chk(ok, "R4 strobe address/data", ok, 1);
        // hold phase
        k = 0; ok = 1;
        while (mem_dq_oe && k < 1000) begin
            if (!mem_we_n || !mem_oe_n || mem_dq_out != d) ok = 0;
            k++;
            @(negedge clk);
        end
        chk(k == E_HOLD, "R5 hold length", k, E_HOLD);
        chk(ok, "R5 hold levels", ok, 1);
        // wait / poll
        first_oe = -1; bend = -1; fin = 0; ok = 1;
        got_done = 0; got_err = 0; busy_at_done = 0; done_k = -1;
        while (!fin && k < 20000) begin
            if (first_oe < 0 && !mem_oe_n) first_oe = k;
            if (bend < 0 && busy_cnt == 0) bend = k;
            if (mem_dq_oe || ack) ok = 0;
            if (done || timeout_err) begin
                fin = 1; got_done = done; got_err = timeout_err;
                done_k = k; busy_at_done = (busy_cnt != 0);
                req = 1'b0;
            end else begin
                k++;
                @(negedge clk);
            end
        end
        chk(ok, "R7 bus released while waiting", ok, 1);
        if (m == 1'b0)
            chk(first_oe == E_HOLD + E_DB, "R6 first read cycle", first_oe, E_HOLD + E_DB);
        else
            chk(first_oe == -1, "R8 no read in pin mode", first_oe, -1);
        if (stk) begin
            chk(got_err && !got_done, "R9 timeout reported", got_err, 1);
            chk(done_k == E_HOLD + E_TO, "R9 timeout cycle", done_k, E_HOLD + E_TO);
        end else begin
            chk(got_done && !got_err, m ? "R8 done by pin" : "R7 done by bit 7", got_done, 1);
            chk(!busy_at_done, "R6 done only after busy ends", busy_at_done, 0);
            ref_k = mx(bend, E_HOLD + E_DB);
            if (m)
                chk(done_k - ref_k <= 4 && done_k > ref_k, "R8 done latency", done_k - ref_k, 4);
            else
                chk(done_k - ref_k <= E_ACC + E_GAP + 3, "R7 done latency",
                    done_k - ref_k, E_ACC + E_GAP + 3);
            chk(model_mem[a] == d, "R4 stored byte", model_mem[a], d);
        end
        @(negedge clk);
        chk(!done && !timeout_err && mem_ce_n && !ack, "R10 one-cycle status then idle",
            {done, timeout_err, mem_ce_n}, 3'b001);
    endtask

    initial begin
        E_SETUP  = mx(mx(cyc(10), cyc(15)), cyc(55));
        E_STROBE = mx(mx(cyc(150), cyc(50)), cyc(100));
        E_HOLD   = mx(cyc(10), cyc(15));
        E_DB     = cyc(80);
        E_ACC    = cyc(200);
        E_GAP    = mx(cyc(15), cyc(55));
        E_TO     = cyc(TO_NS);
        for (int i = 0; i < 2048; i++) model_mem[i] = 8'h00;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !ack && !done && !timeout_err,
            "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle after reset",
            {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        // directed corner cases
        run_txn(11'h000, 8'h80, 1'b0, 1,    0, 0);  // short busy, bit-7 mode
        run_txn(11'h7FF, 8'h7F, 1'b1, 1,    0, 0);  // short busy, pin mode
        run_txn(11'h123, 8'hC3, 1'b0, 2000, 0, 0);  // long busy, several reads
        run_txn(11'h456, 8'h3C, 1'b1, 2000, 0, 0);  // long busy, pin
        run_txn(11'h2AA, 8'h55, 1'b0, 300,  0, 1);  // request held during transaction
        run_txn(11'h155, 8'hAA, 1'b1, 300,  1, 0);  // stuck busy, pin → timeout
        run_txn(11'h0F0, 8'h0F, 1'b0, 300,  1, 0);  // stuck busy, bit 7 → timeout
        run_txn(11'h0F1, 8'h81, 1'b1, 50,   0, 0);  // recovers after timeout
        // constrained random
        for (int t = 0; t < 24; t++) begin
            run_txn(11'($urandom_range(0, 2047)), 8'($urandom_range(0, 255)),
                    1'($urandom_range(0, 1)), int'($urandom_range(1, 2500)), 0,
                    ($urandom_range(0, 3) == 0));
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule